// File: doc/BRIEF.md
# Instruction Break Timing Sequencer

This block decides the moment at which an instruction-address breakpoint becomes a break interrupt request for a simple in-order core. It watches the core's fetch stream and compares each fetched address with a programmed break address. It carries a match tag alongside every fetch that is still queued. Queued fetches that the core throws away, such as fetches made past a taken branch or during an interrupt transition, lose their tag. As a result, only instructions that really execute can cause a break.

Two timing modes are offered. In before-execution mode the break is raised when the matching instruction is committed to execute. In after-execution mode it is raised once that instruction has completed, ahead of the next one. In both modes delivery is postponed while the core cannot take an interrupt: at a delay-slot instruction, or at the instruction that follows an interrupt-inhibiting one. The request then stays asserted until the core acknowledges it.

Top module: `ibrk_timing_seq`

## Requirements
- R1: After reset `brk_req` is low.
- R2: A fetch matches when `fetch_addr` and `cfg_addr` agree on bits AW-1 down to 1. Bit 0 is ignored, and a difference in any higher bit gives no match.
- R3: In before-execution mode (`cfg_after`=0), a matching instruction that starts at an accepting boundary raises `brk_req` in the cycle after its `ex_start`.
- R4: `fetch_kill` discards every queued fetch that has not started, so none of them can produce a break. A fetch presented in the same cycle as the kill is kept, and an instruction starting in that cycle is not affected.
- R5: In after-execution mode (`cfg_after`=1), a matching instruction never raises `brk_req` at its own start. After its `ex_done`, the request is delivered at the next accepting `ex_start`.
- R6: An `ex_start` is an accepting boundary unless `ex_slot` is high or the previously started instruction had `ex_inhib` high. A break reaching a non-accepting boundary is held and delivered at the first later accepting `ex_start`.
- R7: `brk_req` stays high until `irq_ack` is sampled high and is low in the following cycle.
- R8: A break arising while `brk_req` is high is merged into it. After the acknowledge, no second request follows without a new match.
- R9: While `cfg_en` is low, `brk_req` goes low in the next cycle, and all match tags and held breaks are dropped. Matches made before the disable never break later.
- R10: Up to QD fetches (default 2) are tracked in order, and each `ex_start` consumes the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Break enable; low clears all tracking |
| cfg_addr | input | AW | Break instruction address |
| cfg_after | input | 1 | 0 = break before execution, 1 = after execution |
| fetch_valid | input | 1 | An instruction fetch completes this cycle |
| fetch_addr | input | AW | Address of that fetch |
| fetch_kill | input | 1 | Discard all queued fetches not yet started |
| ex_start | input | 1 | The oldest queued instruction starts execution |
| ex_slot | input | 1 | The starting instruction is a delay slot |
| ex_inhib | input | 1 | The starting instruction blocks interrupts at the next boundary |
| ex_done | input | 1 | The executing instruction completes |
| irq_ack | input | 1 | Core accepts the break request |
| brk_req | output | 1 | Break interrupt request, held until acknowledged |

## Verification
On every cycle the assertions check that a request can only rise right after an `ex_start` without `ex_slot` while enabled, and that it holds until acknowledged and clears on acknowledge. They also check that disable clears it and that the fetch queue is never overfilled. Which instruction actually breaks cannot be checked cycle by cycle and is shown only by the bench scenarios. These cover address matching around the break address, the deferral outcome for every mix of mode, delay slot and inhibit flags, kill of speculative fetches, merging, and queue ordering.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
   typedef enum logic {
      BRK_BEFORE = 1'b0,
      BRK_AFTER  = 1'b1
   } brk_mode_e;
endpackage

// File: rtl/ibrk_addr_match.sv
module ibrk_addr_match #(
   parameter int AW      = 32,
   parameter int CMP_LSB = 1
) (
   input  logic [AW-1:0] addr_a,
   input  logic [AW-1:0] addr_b,
   output logic          hit
);
   localparam logic [AW-1:0] MASK = ~((AW'(1) << CMP_LSB) - AW'(1));

   generate
      if (CMP_LSB == 0) begin : g_exact
         assign hit = (addr_a == addr_b);
      end else begin : g_masked
         // low bits below CMP_LSB take no part in the comparison
         assign hit = (((addr_a ^ addr_b) & MASK) == '0);
      end
   endgenerate
endmodule

// File: rtl/ibrk_tag_queue.sv
module ibrk_tag_queue #(
   parameter int QD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic push,
   input  logic push_tag,
   input  logic pop,
   input  logic flush,
   output logic head_tag,
   output logic full
);
   localparam int CW = $clog2(QD + 1);

   logic [QD-1:0] tag_q, tag_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      tag_d = tag_q;
      cnt_d = cnt_q;
      // order inside one cycle: consume oldest, discard rest, append new
      if (pop && cnt_q != '0) begin
         tag_d = tag_q >> 1;
         cnt_d = cnt_q - CW'(1);
      end
      if (flush) begin
         tag_d = '0;
         cnt_d = '0;
      end
      if (push && cnt_d != CW'(QD)) begin
         for (int i = 0; i < QD; i++) begin
            if (CW'(i) == cnt_d) tag_d[i] = push_tag;
         end
         cnt_d = cnt_d + CW'(1);
      end
      if (clr) begin
         tag_d = '0;
         cnt_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= '0;
         cnt_q <= '0;
      end else begin
         tag_q <= tag_d;
         cnt_q <= cnt_d;
      end
   end

   assign head_tag = (cnt_q != '0) && tag_q[0];
   assign full     = (cnt_q == CW'(QD));
endmodule

// File: rtl/ibrk_boundary.sv
module ibrk_boundary
   import ibrk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  brk_mode_e mode,
   input  logic      ex_start,
   input  logic      ex_slot,
   input  logic      ex_inhib,
   input  logic      ex_done,
   input  logic      head_tag,
   output logic      accept,
   output logic      event_now
);
   logic inhib_q;
   logic exec_tag_q;
   logic pre_ev, post_ev;

   assign accept    = ex_start && !ex_slot && !inhib_q;
   assign pre_ev    = ex_start && head_tag && (mode == BRK_BEFORE);
   assign post_ev   = ex_done && exec_tag_q && (mode == BRK_AFTER);
   assign event_now = pre_ev || post_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inhib_q    <= 1'b0;
         exec_tag_q <= 1'b0;
      end else begin
         if (ex_start) inhib_q <= ex_inhib;
         if (clr)
            exec_tag_q <= 1'b0;
         else if (ex_start)
            exec_tag_q <= head_tag;
         else if (ex_done)
            exec_tag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ibrk_request.sv
module ibrk_request (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic accept,
   input  logic event_now,
   input  logic ack,
   output logic req
);
   logic held_q, req_q;
   logic deliver;

   assign deliver = accept && !req_q && (held_q || event_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         req_q  <= 1'b0;
      end else if (clr) begin
         held_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         held_q <= (req_q || deliver) ? 1'b0 : (held_q || event_now);
         req_q  <= deliver || (req_q && !ack);
      end
   end

   assign req = req_q;
endmodule

// File: rtl/ibrk_timing_seq.sv
module ibrk_timing_seq
   import ibrk_pkg::*;
#(
   parameter int AW      = 32,
   parameter int QD      = 2,
   parameter int CMP_LSB = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic [AW-1:0] cfg_addr,
   input  logic          cfg_after,
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_addr,
   input  logic          fetch_kill,
   input  logic          ex_start,
   input  logic          ex_slot,
   input  logic          ex_inhib,
   input  logic          ex_done,
   input  logic          irq_ack,
   output logic          brk_req
);
   generate
      if (QD < 1) begin : g_bad_qd
         $error("ibrk_timing_seq: QD must be at least 1");
      end
      if (CMP_LSB < 0 || CMP_LSB >= AW) begin : g_bad_lsb
         $error("ibrk_timing_seq: CMP_LSB out of range");
      end
   endgenerate

   logic clr;
   logic addr_hit;
   logic head_tag;
   logic q_full;
   logic accept;
   logic event_now;

   assign clr = !cfg_en;

   ibrk_addr_match #(.AW(AW), .CMP_LSB(CMP_LSB)) u_match (
      .addr_a (fetch_addr),
      .addr_b (cfg_addr),
      .hit    (addr_hit)
   );

   ibrk_tag_queue #(.QD(QD)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .push     (fetch_valid),
      .push_tag (addr_hit && cfg_en),
      .pop      (ex_start),
      .flush    (fetch_kill),
      .head_tag (head_tag),
      .full     (q_full)
   );

   ibrk_boundary u_bound (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .mode      (brk_mode_e'(cfg_after)),
      .ex_start  (ex_start),
      .ex_slot   (ex_slot),
      .ex_inhib  (ex_inhib),
      .ex_done   (ex_done),
      .head_tag  (head_tag),
      .accept    (accept),
      .event_now (event_now)
   );

   ibrk_request u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .accept    (accept),
      .event_now (event_now),
      .ack       (irq_ack),
      .req       (brk_req)
   );
endmodule

// File: rtl/ibrk_timing_seq_chk.sv
module ibrk_timing_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_en,
   input logic fetch_valid,
   input logic fetch_kill,
   input logic ex_start,
   input logic ex_slot,
   input logic irq_ack,
   input logic brk_req,
   input logic q_full
);
   // R3 / R6: a request only rises after an accepting-type start
   assert_rise_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_req) |-> ($past(ex_start) && !$past(ex_slot)));

   assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && !irq_ack && cfg_en) |=> brk_req);

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && irq_ack) |=> !brk_req);

   assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !brk_req);

   assert_rise_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_req) |-> $past(cfg_en));

   assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full && !ex_start && !fetch_kill && cfg_en) |-> !fetch_valid);
endmodule

bind ibrk_timing_seq ibrk_timing_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_en      (cfg_en),
   .fetch_valid (fetch_valid),
   .fetch_kill  (fetch_kill),
   .ex_start    (ex_start),
   .ex_slot     (ex_slot),
   .irq_ack     (irq_ack),
   .brk_req     (brk_req),
   .q_full      (q_full)
);

// File: tb/sim_ibrk_timing_seq.sv
module sim_ibrk_timing_seq;
   localparam logic [31:0] BRK = 32'h0000_1002;
   localparam logic [31:0] NM  = 32'h0000_2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0;
   logic [31:0] cfg_addr = BRK;
   logic        cfg_after = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_kill = 1'b0;
   logic        ex_start = 1'b0;
   logic        ex_slot = 1'b0;
   logic        ex_inhib = 1'b0;
   logic        ex_done = 1'b0;
   logic        irq_ack = 1'b0;
   logic        brk_req;

   int checks = 0;
   int errors = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   ibrk_timing_seq u0 (.*);

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic tick();
      @(negedge clk);
      fetch_valid = 1'b0; fetch_kill = 1'b0; ex_start = 1'b0;
      ex_slot = 1'b0; ex_inhib = 1'b0; ex_done = 1'b0; irq_ack = 1'b0;
   endtask

   task automatic chk(input logic got, input logic exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: brk_req=%0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic clear_all();
      cfg_en = 1'b0; tick(); cfg_en = 1'b1;
   endtask
   task automatic fetch(input logic [31:0] a);
      fetch_valid = 1'b1; fetch_addr = a; tick();
   endtask
   task automatic start(input logic slot, input logic inh);
      ex_start = 1'b1; ex_slot = slot; ex_inhib = inh; tick();
   endtask
   task automatic done();
      ex_done = 1'b1; tick();
   endtask
   task automatic ack();
      irq_ack = 1'b1; tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: brk_req=%0b expected run end", brk_req);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(brk_req, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      tick();
      chk(brk_req, 1'b0, "R1 after reset");

      // R2 / R3: address sweep around the break address, before mode
      cfg_after = 1'b0;
      for (int k = 0; k < 9; k++) begin
         logic [31:0] a;
         logic        e;
         a = BRK - 32'd4 + 32'(k);
         e = ((a >> 1) == (BRK >> 1));
         clear_all();
         fetch(a);
         start(1'b0, 1'b0);
         chk(brk_req, e, "R2 R3 address match");
         if (e) begin
            ack();
            chk(brk_req, 1'b0, "R7 ack clears");
         end
      end
      // R2: high bit difference
      clear_all(); fetch(BRK ^ 32'h8000_0000); start(1'b0, 1'b0);
      chk(brk_req, 1'b0, "R2 high bit differs");

      // R5 / R6: mode x slot x previous inhibit x matched inhibit
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 2; p++) begin
               for (int mi = 0; mi < 2; mi++) begin
                  logic a1, e1, e3;
                  a1 = (s == 0) && (p == 0);
                  e1 = (m == 0) && a1;
                  e3 = e1 || (mi == 0);
                  cfg_after = m[0];
                  clear_all();
                  fetch(NM);
                  fetch(BRK);
                  start(1'b0, p[0]);
                  done();
                  start(s[0], mi[0]);
                  chk(brk_req, e1, (m == 0) ? "R3 R6 own start" : "R5 not at own start");
                  done();
                  chk(brk_req, e1, "R5 R6 after completion");
                  fetch(NM);
                  start(1'b0, 1'b0);
                  chk(brk_req, e3, "R5 R6 next boundary");
                  done();
                  fetch(NM);
                  start(1'b0, 1'b0);
                  chk(brk_req, 1'b1, "R6 deferred delivery");
                  ack();
                  chk(brk_req, 1'b0, "R7 cleared");
               end
            end
         end
      end

      // R4: kill of a speculative matching fetch; target fetch in kill cycle
      cfg_after = 1'b0;
      for (int t = 0; t < 2; t++) begin
         clear_all();
         fetch(NM);
         fetch(BRK);
         ex_start = 1'b1; fetch_kill = 1'b1;
         fetch_valid = 1'b1; fetch_addr = (t == 1) ? BRK : NM;
         tick();
         chk(brk_req, 1'b0, "R4 branch start");
         start(1'b0, 1'b0);
         chk(brk_req, t[0], "R4 killed vs kept fetch");
      end

      // R7 / R8: hold and merge
      clear_all();
      fetch(BRK); start(1'b0, 1'b0);
      chk(brk_req, 1'b1, "R7 raised");
      for (int i = 0; i < 3; i++) begin
         tick();
         chk(brk_req, 1'b1, "R7 held");
      end
      fetch(BRK); start(1'b0, 1'b0);
      chk(brk_req, 1'b1, "R8 pending stays");
      ack();
      chk(brk_req, 1'b0, "R8 cleared after ack");
      for (int i = 0; i < 3; i++) begin
         tick();
         chk(brk_req, 1'b0, "R8 merged no second");
      end

      // R9: disable clears tags, held breaks and request
      clear_all();
      fetch(BRK);
      cfg_en = 1'b0; tick(); cfg_en = 1'b1;
      start(1'b0, 1'b0);
      chk(brk_req, 1'b0, "R9 tag dropped");
      cfg_after = 1'b1;
      clear_all();
      fetch(BRK); start(1'b0, 1'b0); done();
      cfg_en = 1'b0; tick(); cfg_en = 1'b1;
      fetch(NM); start(1'b0, 1'b0);
      chk(brk_req, 1'b0, "R9 held dropped");
      cfg_after = 1'b0;
      clear_all();
      fetch(BRK); start(1'b0, 1'b0);
      chk(brk_req, 1'b1, "R9 raised before disable");
      cfg_en = 1'b0; tick();
      chk(brk_req, 1'b0, "R9 request dropped");
      cfg_en = 1'b1; tick();
      chk(brk_req, 1'b0, "R9 stays low");

      // R10: queue order
      clear_all();
      fetch(BRK); fetch(NM);
      start(1'b0, 1'b0);
      chk(brk_req, 1'b1, "R10 oldest first match");
      ack();
      clear_all();
      fetch(NM); fetch(BRK);
      start(1'b0, 1'b0);
      chk(brk_req, 1'b0, "R10 oldest non-match");
      start(1'b0, 1'b0);
      chk(brk_req, 1'b1, "R10 second entry match");
      ack();

      finish_run();
   end
endmodule